// File: doc/BRIEF.md
# GPIO Change-Interrupt Controller with Latching

An eight-pin general-purpose I/O port behind a four-register read/write port. The registers hold pin direction, the output levels, a per-pin interrupt mask and a control word. Input pins are first brought into the clock domain. Any input pin whose level moves away from a stored reference level raises the interrupt output, provided the pin is unmasked. A read of the pin-level register moves the reference to the current levels.

In the default mode the interrupt follows the pin. It drops by itself when the pin returns to its reference level. In capture mode the interrupt is sticky and the new level of the pin is frozen in the pin-level register, so a short glitch is still seen by the host. Only a read of the pin-level register releases it. Either half of the port can be given over to modem-signal duty. That half is then taken out of the direction, level and mask logic, and a separate enable controls a change pulse for it. A control bit resets all registers and clears itself.

Top module: `gpio_chg_irq`

## Requirements
- R1: After reset all four registers read 0x00, `pin_oe` is 0x00 and `irq` is low.
- R2: Offset 0 is direction (bit=1 output) and offset 1 is pin level. A write to offset 1 sets the output levels. `pin_oe` equals direction and `pin_out` carries the written levels on output pins. A read of offset 1 returns the written level for output pins and the pin level for input pins.
- R3: An input pin passes through a two-flop synchroniser. A level applied at the pin appears in a read of offset 1 after at most three clock edges.
- R4: With control bit 0 clear, a change on an unmasked input raises `irq`. `irq` falls again if the pin returns to its reference level, and it clears when offset 1 is read, which makes the current levels the new reference.
- R5: A pin whose bit at offset 2 (interrupt mask, 1 = enabled) is 0, or a pin set as output, never raises `irq`.
- R6: With control bit 0 set (capture mode), a change on an unmasked input raises `irq` and freezes the new level in that bit of offset 1. The interrupt and the frozen level stay after the pin reverts, until offset 1 is read.
- R7: Control bit 1 gives pins 7:4 and control bit 2 gives pins 3:0 to modem use. Those pins are then never driven, read 0 at offset 1, and raise no `irq`.
- R8: `modem_chg[1]` (pins 7:4) and `modem_chg[0]` (pins 3:0) pulse for one cycle per synchronised level change on a modem-assigned nibble, and only while `modem_irq_en` is high.
- R9: Writing offset 3 with bit 3 set clears every register on the next edge. Control bits 7:3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 8 | Pin input levels, asynchronous |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |
| modem_irq_en | input | 1 | Enable for modem-nibble change pulses |
| irq | output | 1 | Pin-change interrupt |
| modem_chg | output | 2 | Per-nibble modem change pulse |

## Verification
A wrong reference or pending state shows up at `irq` within three edges of a pin change. The sticky capture logic is tested by a glitch that reverts before the host reads: a design that loses the pending bit drops `irq`, and one that does not freeze the level shows the reverted value at offset 1. Mis-masking of modem nibbles shows up at once in `pin_oe`, in the offset-1 read, or as a change pulse while the enable is low.

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic         modem_irq_en,
  output logic         irq,
  output logic [1:0]   modem_chg
);
  localparam int H = W / 2;

  logic [W-1:0] s1, sv, prv;
  logic [W-1:0] dir, outq, ien, refv, pend_q, latv;
  logic [2:0]   ctrl;
  logic [W-1:0] gmask, chg, in_view, st_view, pin_req;
  logic         st_rd, sres;

  assign st_rd = rd_en && addr == 2'd1;
  assign sres  = wr_en && addr == 2'd3 && wdata[3];
  assign gmask = {{H{~ctrl[1]}}, {H{~ctrl[2]}}};

  assign chg     = ien & ~dir & gmask & (sv ^ refv);
  assign in_view = ctrl[0] ? ((pend_q & latv) | (~pend_q & sv)) : sv;
  assign st_view = gmask & ((dir & outq) | (~dir & in_view));
  assign pin_req = ctrl[0] ? pend_q : chg;
  assign irq     = |(pin_req & ien & ~dir & gmask);

  assign pin_oe  = dir & gmask;
  assign pin_out = outq & gmask;

  assign modem_chg[1] = modem_irq_en & ctrl[1] & |(sv[W-1:H] ^ prv[W-1:H]);
  assign modem_chg[0] = modem_irq_en & ctrl[2] & |(sv[H-1:0] ^ prv[H-1:0]);

  always_comb begin
    case (addr)
      2'd0:    rdata = dir;
      2'd1:    rdata = st_view;
      2'd2:    rdata = ien;
      default: rdata = {5'b0, ctrl};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '0;
      sv  <= '0;
      prv <= '0;
    end else begin
      s1  <= pin_in;
      sv  <= s1;
      prv <= sv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '0; outq <= '0; ien <= '0; ctrl <= '0;
      refv <= '0; pend_q <= '0; latv <= '0;
    end else if (sres) begin
      dir <= '0; outq <= '0; ien <= '0; ctrl <= '0;
      refv <= '0; pend_q <= '0; latv <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          2'd0:    dir  <= wdata;
          2'd1:    outq <= wdata;
          2'd2:    ien  <= wdata;
          default: ctrl <= wdata[2:0];
        endcase
      end
      if (st_rd) refv <= sv;
      latv <= (chg & ~pend_q & sv) | (~(chg & ~pend_q) & latv);
      if (!ctrl[0] || st_rd) pend_q <= '0;
      else                   pend_q <= pend_q | chg;
    end
  end

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !st_rd && !wr_en) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R6
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && st_rd) |=> (pend_q == '0)); // R6
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sres |=> (dir == '0 && ien == '0 && ctrl == '0 && outq == '0)); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ien & ~dir & gmask) != '0)); // R5
  AST_CTRL_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |-> (rdata[7:3] == 5'd0)); // R9
endmodule

// File: tb/gpio_chg_irq_bench.sv
`timescale 1ns/100ps
module gpio_chg_irq_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, modem_irq_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pin_in = 0;
  logic [7:0] rdata, pin_out, pin_oe;
  logic irq;
  logic [1:0] modem_chg;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_chg_irq u_gpio_chg_irq (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .pin_in, .pin_out, .pin_oe, .modem_irq_en, .irq, .modem_chg);

  // {dir, out, pins, expected offset-1 read}
  localparam logic [31:0] VEC [5] = '{
    32'h00_00_A5_A5, 32'hFF_3C_A5_3C, 32'hF0_5A_0F_5F,
    32'h0F_FF_80_8F, 32'h81_01_7E_7F };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic count_pulses(output int c1, output int c0);
    c1 = 0; c0 = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      c1 += int'(modem_chg[1]); c0 += int'(modem_chg[0]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int c1, c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); check("R1 reg", d, 8'h00);
    end

    // R2 R3 vector walk
    for (int i = 0; i < 5; i++) begin
      wr(2'd0, VEC[i][31:24]);
      wr(2'd1, VEC[i][23:16]);
      pin_in = VEC[i][15:8];
      repeat (3) @(negedge clk);
      rd(2'd1, d); check("R2/R3 state read", d, VEC[i][7:0]);
      check("R2 pin_oe", pin_oe, VEC[i][31:24]);
      check("R2 pin_out", pin_out & VEC[i][31:24], VEC[i][23:16] & VEC[i][31:24]);
    end
    wr(2'd0, 8'h00); pin_in = 8'h00; settle(); rd(2'd1, d);

    // R4 non-latched
    wr(2'd2, 8'h01);
    pin_in = 8'h01; settle();
    check("R4 irq on change", {7'd0, irq}, 8'h01);
    pin_in = 8'h00; settle();
    check("R4 irq drops on revert", {7'd0, irq}, 8'h00);
    pin_in = 8'h01; settle();
    rd(2'd1, d); check("R4 read value", d, 8'h01);
    check("R4 irq cleared by read", {7'd0, irq}, 8'h00);
    pin_in = 8'h00; settle(); rd(2'd1, d);

    // R5 masked and output pins
    pin_in = 8'h02; settle();
    check("R5 masked pin", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h01); pin_in = 8'h03; settle();
    check("R5 output pin", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h00); pin_in = 8'h00; settle(); rd(2'd1, d);

    // R6 capture mode
    wr(2'd3, 8'h01); wr(2'd2, 8'hFF);
    pin_in = 8'h04; settle();
    pin_in = 8'h00; settle();
    check("R6 irq sticky", {7'd0, irq}, 8'h01);
    rd(2'd1, d); check("R6 frozen level", d, 8'h04);
    check("R6 irq released", {7'd0, irq}, 8'h00);
    rd(2'd1, d); check("R6 live after read", d, 8'h00);

    // R7 modem nibble
    wr(2'd3, 8'h02); wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    check("R7 upper not driven", pin_oe, 8'h0F);
    rd(2'd1, d); check("R7 state read", d, 8'h0F);
    wr(2'd0, 8'h00); rd(2'd1, d);
    pin_in = 8'h30; settle();
    check("R7 no gpio irq", {7'd0, irq}, 8'h00);

    // R8 modem pulses
    wr(2'd3, 8'h06);
    fork
      count_pulses(c1, c0);
      begin @(negedge clk); pin_in = 8'h10; end
    join
    check("R8 gate off upper", c1[7:0], 8'd0);
    modem_irq_en = 1;
    fork
      count_pulses(c1, c0);
      begin @(negedge clk); pin_in = 8'h00; end
    join
    check("R8 upper pulse", c1[7:0], 8'd1);
    check("R8 lower quiet", c0[7:0], 8'd0);
    fork
      count_pulses(c1, c0);
      begin @(negedge clk); pin_in = 8'h02; end
    join
    check("R8 lower pulse", c0[7:0], 8'd1);
    modem_irq_en = 0;

    // R9 soft reset
    wr(2'd3, 8'h00); wr(2'd0, 8'hA5); wr(2'd2, 8'hFF); wr(2'd3, 8'h03);
    rd(2'd3, d); check("R9 ctrl readback", d, 8'h03);
    wr(2'd3, 8'hF9);
    rd(2'd0, d); check("R9 dir cleared", d, 8'h00);
    rd(2'd2, d); check("R9 mask cleared", d, 8'h00);
    rd(2'd3, d); check("R9 ctrl cleared", d, 8'h00);
    wr(2'd3, 8'hF1);
    rd(2'd3, d); check("R9 reserved read 0", d, 8'h01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule